// File: doc/BRIEF.md
# High-Side Output Fault Supervisor

This block sits between a latched eight-bit driver command and the gate enables of eight high-side switches. Each cycle it decides which channels may really conduct. It takes into account four things: the health of the logic and battery rails, a power-down input, a latched over-temperature fault, and a per-channel short-to-ground detector. It also returns one diagnostic bit per channel, which a serial snapshot register captures. Comparing a diagnostic bit with its command bit tells software whether that output is behaving as requested.

A short to ground is not acted on at once. A per-channel counter runs on a prescaled tick, and the channel is cut off only when the short has lasted the full debounce window. Detection is suspended while the battery is below its 7 V threshold. Over-temperature is handled globally and is sticky. Once the thermal flag rises, every channel is forced off and every diagnostic bit reads as a fault. The fault is released only by a correctly sized serial frame that arrives after the die has cooled. A frame that arrives while the die is still hot does nothing, and cooling without a frame does nothing either.

Top module: `hsd_fault_supervisor`

## Requirements
- R1: While reset is asserted, every gate enable and every diagnostic bit is 0.
- R2: With both rails present, power-down input high, no thermal fault and no shorts, each gate enable equals its command bit one clock after the command. Each diagnostic bit then equals its gate enable (1 = output high).
- R3: A missing logic rail (`vlogic_ok_i` = 0) forces all gate enables to 0 one clock later.
- R4: A missing battery rail (`vbat_ok_i` = 0) forces all gate enables to 0 one clock later.
- R5: Power-down input low (`pdn_n_i` = 0) forces all gate enables to 0 one clock later.
- R6: A channel that is commanded on and sees a continuous short is switched off after no fewer than (DEB_TICKS-1)*TICK_DIV+1 and no more than DEB_TICKS*TICK_DIV clocks. With the defaults (50 MHz clock) the upper bound is 5.0 ms.
- R7: If the short flag drops for even one clock, the channel's debounce count restarts from zero.
- R8: While `vbat_7v_i` is 0, no short is detected and the debounce count is held at zero.
- R9: A channel that was cut off by a short stays off until its command bit goes to 0. Once the command returns to 1, the channel drives again.
- R10: A high `ovtemp_i` latches a thermal fault, and one clock later all gate enables and all diagnostic bits are 0.
- R11: A `frame_ok_i` pulse while `ovtemp_i` is still 1 leaves the thermal fault latched.
- R12: The thermal fault clears only on a `frame_ok_i` pulse with `ovtemp_i` at 0. Cooling alone keeps it latched, and the commanded channels drive again one clock after the clearing pulse.
- R13: A channel that is driven while its short flag is 1 reports diagnostic 0, which mismatches its command of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | NUM_CH | Latched driver command, 1 = on |
| short_i | input | NUM_CH | Per-channel short-to-ground comparator flag |
| ovtemp_i | input | 1 | Over-temperature flag (hysteresis outside) |
| vlogic_ok_i | input | 1 | Logic rail present |
| vbat_ok_i | input | 1 | Battery rail present |
| vbat_7v_i | input | 1 | Battery at or above 7 V |
| pdn_n_i | input | 1 | Power-down input, low = all off |
| frame_ok_i | input | 1 | One-clock pulse for a serial frame whose clock count was a multiple of eight |
| gate_o | output | NUM_CH | Gate enables to the high-side switches |
| diag_o | output | NUM_CH | Diagnostic bits, 1 = output high, 0 = low or fault |

## Verification
The assertions assume that every input is synchronous to `clk` and that `frame_ok_i` is a single-clock pulse. They also assume `cmd_i` changes only when a new frame is loaded, so a channel held off by a short is released only by an explicit off command. The stimulus changes inputs only on falling clock edges, raises `frame_ok_i` for exactly one clock, and always holds a short continuously for longer than one full debounce window whenever it expects a trip. This keeps every expected transition inside the bounds that the properties state.

// File: rtl/hsd_sup_pkg.sv
package hsd_sup_pkg;

    typedef enum logic [1:0] {
        DEB_IDLE  = 2'd0,
        DEB_COUNT = 2'd1,
        DEB_TRIP  = 2'd2
    } deb_phase_e;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/hsd_tick_gen.sv
module hsd_tick_gen #(
    parameter int DIV = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    import hsd_sup_pkg::*;

    localparam int CW = cnt_width(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] pre_d, pre_q;

    always_comb begin
        tick_o = (pre_q == LAST);
        pre_d  = tick_o ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/hsd_short_deb.sv
module hsd_short_deb #(
    parameter int TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic arm_i,
    input  logic clr_i,
    output logic trip_d_o,
    output logic trip_q_o
);
    import hsd_sup_pkg::*;

    localparam int CW = cnt_width(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    typedef struct packed {
        deb_phase_e    phase;
        logic [CW-1:0] cnt;
    } deb_state_t;

    deb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.phase = DEB_IDLE;
            st_d.cnt   = '0;
        end else if (st_q.phase == DEB_TRIP) begin
            st_d = st_q;
        end else if (!arm_i) begin
            st_d.phase = DEB_IDLE;
            st_d.cnt   = '0;
        end else if (tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.phase = DEB_TRIP;
                st_d.cnt   = '0;
            end else begin
                st_d.phase = DEB_COUNT;
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end
        trip_d_o = (st_d.phase == DEB_TRIP);
        trip_q_o = (st_q.phase == DEB_TRIP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= DEB_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/hsd_fault_supervisor.sv
module hsd_fault_supervisor #(
    parameter int NUM_CH    = 8,
    parameter int TICK_DIV  = 5000,
    parameter int DEB_TICKS = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cmd_i,
    input  logic [NUM_CH-1:0] short_i,
    input  logic              ovtemp_i,
    input  logic              vlogic_ok_i,
    input  logic              vbat_ok_i,
    input  logic              vbat_7v_i,
    input  logic              pdn_n_i,
    input  logic              frame_ok_i,
    output logic [NUM_CH-1:0] gate_o,
    output logic [NUM_CH-1:0] diag_o
);

    typedef struct packed {
        logic              th;
        logic [NUM_CH-1:0] gate;
        logic [NUM_CH-1:0] diag;
    } sup_reg_t;

    sup_reg_t          r_d, r_q;
    logic              tick;
    logic              pwr_ok;
    logic [NUM_CH-1:0] trip_d;
    logic [NUM_CH-1:0] trip_q;
    logic [NUM_CH-1:0] arm;

    hsd_tick_gen #(.DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    assign pwr_ok = vlogic_ok_i & vbat_ok_i & pdn_n_i;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            arm[c] = cmd_i[c] & short_i[c] & vbat_7v_i & pwr_ok & ~r_q.th;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_deb
        hsd_short_deb #(.TICKS(DEB_TICKS)) deb_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick),
            .arm_i    (arm[g]),
            .clr_i    (~cmd_i[g]),
            .trip_d_o (trip_d[g]),
            .trip_q_o (trip_q[g])
        );
    end

    always_comb begin
        r_d = r_q;
        if (ovtemp_i)        r_d.th = 1'b1;
        else if (frame_ok_i) r_d.th = 1'b0;
        r_d.gate = cmd_i & ~trip_d & {NUM_CH{pwr_ok & ~r_d.th}};
        r_d.diag = r_d.gate & ~short_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.th   <= 1'b0;
            r_q.gate <= '0;
            r_q.diag <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_o = r_q.gate;
    assign diag_o = r_q.diag;

endmodule

// File: rtl/hsd_sup_chk.sv
module hsd_sup_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] cmd_i,
    input logic           ovtemp_i,
    input logic           frame_ok_i,
    input logic           vlogic_ok_i,
    input logic           vbat_ok_i,
    input logic           pdn_n_i,
    input logic           th_q,
    input logic [NCH-1:0] trip_q,
    input logic [NCH-1:0] gate_o,
    input logic [NCH-1:0] diag_o
);

    // R2
    gate_within_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((gate_o & ~$past(cmd_i)) == '0));

    // R3
    logic_rail_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vlogic_ok_i |=> (gate_o == '0));

    // R4
    bat_rail_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vbat_ok_i |=> (gate_o == '0));

    // R5
    powerdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n_i |=> (gate_o == '0));

    // R10
    thermal_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovtemp_i |=> (gate_o == '0 && diag_o == '0 && th_q));

    // R11
    hot_frame_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovtemp_i && frame_ok_i) |=> th_q);

    // R12
    cool_alone_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (th_q && !frame_ok_i) |=> th_q);

    // R9
    short_latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((trip_q & cmd_i) != '0) |=> ((gate_o & $past(trip_q & cmd_i)) == '0));

endmodule

bind hsd_fault_supervisor hsd_sup_chk #(.NCH(NUM_CH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .ovtemp_i    (ovtemp_i),
    .frame_ok_i  (frame_ok_i),
    .vlogic_ok_i (vlogic_ok_i),
    .vbat_ok_i   (vbat_ok_i),
    .pdn_n_i     (pdn_n_i),
    .th_q        (r_q.th),
    .trip_q      (trip_q),
    .gate_o      (gate_o),
    .diag_o      (diag_o)
);

// File: tb/hsd_fault_supervisor_tb_top.sv
module hsd_fault_supervisor_tb_top;

    localparam int NCH = 8;
    localparam int TD  = 4;
    localparam int DT  = 5;
    localparam int T_HOLD = (DT - 1) * TD;
    localparam int T_TRIP = DT * TD;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] cmd, shrt;
    logic           ovtemp, vlogic, vbat, v7, pdn_n, frame;
    logic [NCH-1:0] gate, diag;

    always #10 clk = ~clk;

    hsd_fault_supervisor #(.NUM_CH(NCH), .TICK_DIV(TD), .DEB_TICKS(DT)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .short_i     (shrt),
        .ovtemp_i    (ovtemp),
        .vlogic_ok_i (vlogic),
        .vbat_ok_i   (vbat),
        .vbat_7v_i   (v7),
        .pdn_n_i     (pdn_n),
        .frame_ok_i  (frame),
        .gate_o      (gate),
        .diag_o      (diag)
    );

    typedef struct {
        int             due;
        logic [NCH-1:0] g;
        logic [NCH-1:0] d;
        string          tag;
    } exp_t;

    exp_t sb_q[$];
    int   cyc   = 0;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int k, input logic [NCH-1:0] g,
                        input logic [NCH-1:0] d, input string tag);
        exp_t e;
        e.due = cyc + k;
        e.g   = g;
        e.d   = d;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares every due item away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (gate !== e.g || diag !== e.d) begin
                bad++;
                $display("FAIL %s gate=%h exp=%h diag=%h exp=%h",
                         e.tag, gate, e.g, diag, e.d);
            end
        end
    end

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog gate=%h exp=done diag=%h", gate, diag);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd = '0; shrt = '0; ovtemp = 1'b0;
        vlogic = 1'b1; vbat = 1'b1; v7 = 1'b1; pdn_n = 1'b1; frame = 1'b0;
        step(1);
        cmd = 8'hFF;
        push(1, 8'h00, 8'h00, "R1 reset state");
        step(3);
        cmd = 8'h00;
        rst_n = 1'b1;
        step(2);

        // R2 several patterns
        cmd = 8'hA5; push(1, 8'hA5, 8'hA5, "R2 pattern A5"); step(2);
        cmd = 8'h5A; push(1, 8'h5A, 8'h5A, "R2 pattern 5A"); step(2);
        cmd = 8'hFF; push(1, 8'hFF, 8'hFF, "R2 pattern FF"); step(2);

        // R3, R4, R5 rails and power-down
        vlogic = 1'b0; push(1, 8'h00, 8'h00, "R3 logic rail lost"); step(2);
        vlogic = 1'b1; push(1, 8'hFF, 8'hFF, "R3 logic rail back"); step(2);
        vbat = 1'b0;   push(1, 8'h00, 8'h00, "R4 battery lost"); step(2);
        vbat = 1'b1;   push(1, 8'hFF, 8'hFF, "R4 battery back"); step(2);
        pdn_n = 1'b0;  push(1, 8'h00, 8'h00, "R5 power-down"); step(2);
        pdn_n = 1'b1;  push(1, 8'hFF, 8'hFF, "R5 power-down released"); step(2);

        // R13 and R6 debounce window on channel 2
        shrt[2] = 1'b1;
        push(1,      8'hFF, 8'hFB, "R13 shorted channel diag mismatch");
        push(T_HOLD, 8'hFF, 8'hFB, "R6 still driven inside window");
        push(T_TRIP, 8'hFB, 8'hFB, "R6 cut off at window end");
        step(T_TRIP + 1);

        // R9 latched off until command cycles
        shrt[2] = 1'b0; push(1, 8'hFB, 8'hFB, "R9 stays off after short gone"); step(3);
        cmd = 8'hFB;    push(1, 8'hFB, 8'hFB, "R9 command off"); step(2);
        cmd = 8'hFF;    push(1, 8'hFF, 8'hFF, "R9 rearmed by new command"); step(2);

        // R7 short glitch restarts count on channel 3
        shrt[3] = 1'b1; step(12);
        shrt[3] = 1'b0; step(1);
        shrt[3] = 1'b1;
        push(T_HOLD, 8'hFF, 8'hF7, "R7 count restarted after glitch");
        push(T_TRIP, 8'hF7, 8'hF7, "R7 trip after full fresh window");
        step(T_TRIP + 1);
        shrt[3] = 1'b0; cmd = 8'hF7; step(2);
        cmd = 8'hFF; push(1, 8'hFF, 8'hFF, "R9 channel 3 rearmed"); step(2);

        // R8 no detection below 7 V
        v7 = 1'b0; shrt[0] = 1'b1;
        push(1,  8'hFF, 8'hFE, "R8 low battery short diag");
        push(30, 8'hFF, 8'hFE, "R8 no cut-off below 7V");
        step(31);
        shrt[0] = 1'b0; push(1, 8'hFF, 8'hFF, "R8 short removed"); step(2);
        v7 = 1'b1; step(1);

        // R10, R11, R12 thermal latch
        ovtemp = 1'b1; push(1, 8'h00, 8'h00, "R10 thermal trip"); step(2);
        frame = 1'b1; step(1);
        frame = 1'b0; ovtemp = 1'b0;
        push(1, 8'h00, 8'h00, "R11 hot frame ignored");
        push(6, 8'h00, 8'h00, "R12 cooling alone keeps latch");
        step(7);
        frame = 1'b1; push(1, 8'hFF, 8'hFF, "R12 frame after cooling clears"); step(1);
        frame = 1'b0; step(3);

        while (sb_q.size() > 0) step(1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule